// File: doc/BRIEF.md
# Asynchronous Write Responder

This block is the memory-side end of an asynchronous, strobe-based write bus. A master drives an address, a size code, a read/write flag and 32 bits of write data. It then lowers an address strobe and, once the data is stable, a data strobe. The responder brings both strobes into its own clock domain. It captures the cycle and stores the selected byte lanes into a small internal word array. It then lowers a two-bit acknowledge. Both acknowledge bits go low together, which reports a full 32-bit port.

A programmable count sets how long the responder waits before it stores the data and acknowledges. While it waits, both acknowledge bits stay high, so the master keeps inserting wait states. After it acknowledges, the responder holds the acknowledge until it sees the first of the two strobes go high. One clock after that it releases the acknowledge, so a late acknowledge cannot be taken for the next cycle's. Read cycles get no response. The stored array is brought out as a flat vector for the logic that consumes it.

Top module: `async_wr_responder`

## Requirements
- R1: Bus bits 8k+7..8k form byte lane k, and lane 3 (bits 31..24) holds address offset 0. The size code gives the byte count: 2'b01 is one byte, 2'b10 is two bytes, 2'b11 is three bytes and 2'b00 is four bytes. For a cycle at offset a (the address bits 1..0), only the lanes for offsets a up to a+count-1 are written, clipped at offset 3. Every other byte of the word keeps its value.
- R2: The address bits above bit 1 select the target word, and no other word changes. Word w appears on `words_o[32*w+31:32*w]`.
- R3: Both acknowledge bits are driven low together, and never one without the other. When the acknowledge goes low, the written data is already visible on `words_o`.
- R4: With the wait count c (0..7) taken at the start of the cycle, the acknowledge goes low on the (c+4)th rising clock edge after `ds_n_i` falls. This count includes two synchronizer stages. Until then, both acknowledge bits stay high.
- R5: Once asserted, the acknowledge stays low for as long as both strobes remain low.
- R6: The acknowledge returns to 2'b11 on the third rising edge after whichever strobe rises first. This count includes two synchronizer stages.
- R7: A cycle with `rw_i` = 1 (read) is ignored: no acknowledge is given and no stored byte changes.
- R8: After a cycle is released and both strobes are high again, the next write is accepted and acknowledged with the same timing.
- R9: While reset is held and immediately after it, the acknowledge reads 2'b11 and every stored word reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Responder clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| as_n_i | input | 1 | Address strobe, active low, asynchronous |
| ds_n_i | input | 1 | Data strobe, active low, asynchronous |
| rw_i | input | 1 | 1 = read cycle (ignored), 0 = write cycle |
| siz_i | input | 2 | Transfer size code |
| addr_i | input | ADDR_W | Byte address; bits 1..0 are the offset, the upper bits pick a word |
| data_i | input | 32 | Write data, aligned to byte lanes |
| wait_cfg_i | input | WAIT_W | Wait count before the acknowledge |
| ack_n_o | output | 2 | Acknowledge, active low, both bits driven together |
| words_o | output | 32*2^(ADDR_W-2) | Flat image of the stored word array |

## Verification
The embedded properties check the following on every clock:
- The acknowledge is held while both synchronized strobes stay low, and dropped on the edge after either strobe rises.
- A read never leaves the idle state.
- The number of wait cycles spent equals the captured count.
- Words that are not addressed never change.
- An offset-3 access enables only lane 0.
- The acknowledge rises only on the edge that stores the data.

The scoreboard bench covers what depends on the asynchronous pins and on the data values. This includes the exact edge counts from strobe edge to acknowledge edge, with the synchronizer delay included. It also includes the lane patterns for every size and offset against an independent table, and the full array image after each write. Finally, it covers the absence of any response or store during a held read, and back-to-back writes.

// File: rtl/wresp_pkg.sv
package wresp_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACK  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/wresp_sync.sv
module wresp_sync #(
    parameter int               WIDTH   = 2,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [WIDTH-1:0] stage_d;
        if (s == 0) begin : g_first
            assign stage_d = d_i;
        end else begin : g_next
            assign stage_d = chain_q[s-1];
        end
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[s] <= RST_VAL;
            else         chain_q[s] <= stage_d;
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/wresp_lane_dec.sv
module wresp_lane_dec
    import wresp_pkg::*;
(
    input  logic [1:0]       siz_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [LANES-1:0] mask_o
);

    int nbytes;
    int first_ofs;

    always_comb begin
        nbytes    = (siz_i == 2'b00) ? LANES : int'(siz_i);
        first_ofs = int'(off_i);
    end

    // lane k carries offset LANES-1-k (big-endian byte order)
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int OFS = LANES - 1 - k;
        assign mask_o[k] = (OFS >= first_ofs) && (OFS < first_ofs + nbytes);
    end

endmodule

// File: rtl/wresp_store.sv
module wresp_store
    import wresp_pkg::*;
#(
    parameter int WORDS = 4,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    we_i,
    input  logic [IDX_W-1:0]        idx_i,
    input  logic [LANES-1:0]        mask_i,
    input  logic [DATA_W-1:0]       data_i,
    output logic [WORDS*DATA_W-1:0] image_o
);

    logic [DATA_W-1:0] mem_d [WORDS];
    logic [DATA_W-1:0] mem_q [WORDS];

    always_comb begin
        mem_d = mem_q;
        if (we_i) begin
            for (int k = 0; k < LANES; k++) begin
                if (mask_i[k]) mem_d[idx_i][k*LANE_W +: LANE_W] = data_i[k*LANE_W +: LANE_W];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int w = 0; w < WORDS; w++) mem_q[w] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        assign image_o[w*DATA_W +: DATA_W] = mem_q[w];

        // R2: a word that is not the write target keeps its value
        assert_untouched_word_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(we_i && (idx_i == IDX_W'(w))) |=> $stable(mem_q[w]));
    end

endmodule

// File: rtl/wresp_seq.sv
module wresp_seq
    import wresp_pkg::*;
#(
    parameter int WAIT_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              as_act_i,
    input  logic              ds_act_i,
    input  logic              rw_i,
    input  logic [WAIT_W-1:0] cfg_i,
    output logic              start_o,
    output logic              we_o,
    output logic              ack_o
);

    typedef struct packed {
        seq_state_e        st;
        logic [WAIT_W-1:0] cnt;
        logic              ack;
    } seq_t;

    localparam seq_t SEQ_RST = '{st: ST_IDLE, cnt: '0, ack: 1'b0};

    seq_t seq_d, seq_q;
    logic both_low;

    always_comb begin
        seq_d    = seq_q;
        start_o  = 1'b0;
        we_o     = 1'b0;
        both_low = as_act_i && ds_act_i;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (both_low && !rw_i) begin
                    start_o   = 1'b1;
                    seq_d.st  = ST_WAIT;
                    seq_d.cnt = cfg_i;
                end
            end
            ST_WAIT: begin
                if (seq_q.cnt == '0) begin
                    we_o      = 1'b1;
                    seq_d.ack = 1'b1;
                    seq_d.st  = ST_ACK;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_ACK: begin
                if (!both_low) begin
                    seq_d.ack = 1'b0;
                    seq_d.st  = ST_IDLE;
                end
            end
            default: seq_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seq_q <= SEQ_RST;
        else         seq_q <= seq_d;
    end

    assign ack_o = seq_q.ack;

    // checker state: wait cycles actually spent versus the count taken at start
    logic [WAIT_W:0]   waited_q;
    logic [WAIT_W-1:0] cfg_seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            waited_q   <= '0;
            cfg_seen_q <= '0;
        end else if (start_o) begin
            waited_q   <= '0;
            cfg_seen_q <= cfg_i;
        end else if (seq_q.st == ST_WAIT && !we_o) begin
            waited_q <= waited_q + 1'b1;
        end
    end

    assert_wait_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_o |-> (waited_q == {1'b0, cfg_seen_q}));

    assert_ack_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_o && as_act_i && ds_act_i) |=> ack_o);

    assert_ack_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_o && !(as_act_i && ds_act_i)) |=> !ack_o);

    assert_read_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.st == ST_IDLE && rw_i) |=> (seq_q.st == ST_IDLE));

endmodule

// File: rtl/async_wr_responder.sv
module async_wr_responder
    import wresp_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int WAIT_W      = 3,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W = ADDR_W - OFF_W,
    localparam int WORDS = 2 ** IDX_W
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    as_n_i,
    input  logic                    ds_n_i,
    input  logic                    rw_i,
    input  logic [1:0]              siz_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [DATA_W-1:0]       data_i,
    input  logic [WAIT_W-1:0]       wait_cfg_i,
    output logic [1:0]              ack_n_o,
    output logic [WORDS*DATA_W-1:0] words_o
);

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [OFF_W-1:0]  off;
        logic [1:0]        siz;
        logic [DATA_W-1:0] data;
    } cap_t;

    logic [1:0]       strobe_n_s;
    logic             as_act, ds_act;
    logic             start, we, ack;
    logic [LANES-1:0] mask;
    cap_t             cap_d, cap_q;

    wresp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    ({as_n_i, ds_n_i}),
        .q_o    (strobe_n_s)
    );

    assign as_act = ~strobe_n_s[1];
    assign ds_act = ~strobe_n_s[0];

    wresp_seq #(.WAIT_W(WAIT_W)) i_seq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .as_act_i (as_act),
        .ds_act_i (ds_act),
        .rw_i     (rw_i),
        .cfg_i    (wait_cfg_i),
        .start_o  (start),
        .we_o     (we),
        .ack_o    (ack)
    );

    // cycle attributes are stable while the strobes are low; take them at start
    always_comb begin
        cap_d = cap_q;
        if (start) begin
            cap_d.idx  = addr_i[ADDR_W-1:OFF_W];
            cap_d.off  = addr_i[OFF_W-1:0];
            cap_d.siz  = siz_i;
            cap_d.data = data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cap_q <= '0;
        else         cap_q <= cap_d;
    end

    wresp_lane_dec i_lane_dec (
        .siz_i  (cap_q.siz),
        .off_i  (cap_q.off),
        .mask_o (mask)
    );

    wresp_store #(.WORDS(WORDS)) i_store (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (we),
        .idx_i   (cap_q.idx),
        .mask_i  (mask),
        .data_i  (cap_q.data),
        .image_o (words_o)
    );

    // a full-width port answers with both bits together
    assign ack_n_o = {2{~ack}};

    assert_ack_after_store_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ack) |-> $past(we));

    assert_last_offset_lane_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cap_q.off == OFF_W'(LANES - 1)) |-> (mask == LANES'(1)));

endmodule

// File: tb/test_async_wr_responder.sv
module test_async_wr_responder;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 4;
    localparam int WAIT_W     = 3;
    localparam int WORDS      = 4;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  as_n = 1'b1, ds_n = 1'b1, rw = 1'b0;
    logic [1:0]            siz = 2'b00;
    logic [ADDR_W-1:0]     addr = '0;
    logic [31:0]           data = '0;
    logic [WAIT_W-1:0]     wait_cfg = '0;
    logic [1:0]            ack_n;
    logic [WORDS*32-1:0]   words;

    int checks = 0;
    int failures = 0;
    int acks_seen = 0;
    int writes_sent = 0;

    typedef struct {
        int                  lat;
        int                  idx;
        logic [WORDS*32-1:0] image;
    } item_t;

    item_t sb[$];
    logic [31:0] model [WORDS];

    always #(CLK_PERIOD/2) clk = ~clk;

    async_wr_responder #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) i_async_wr_responder (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .as_n_i     (as_n),
        .ds_n_i     (ds_n),
        .rw_i       (rw),
        .siz_i      (siz),
        .addr_i     (addr),
        .data_i     (data),
        .wait_cfg_i (wait_cfg),
        .ack_n_o    (ack_n),
        .words_o    (words)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_mask(input logic [1:0] sz, input logic [1:0] off);
        case ({sz, off})
            4'b01_00: return 4'b1000;
            4'b01_01: return 4'b0100;
            4'b01_10: return 4'b0010;
            4'b01_11: return 4'b0001;
            4'b10_00: return 4'b1100;
            4'b10_01: return 4'b0110;
            4'b10_10: return 4'b0011;
            4'b10_11: return 4'b0001;
            4'b11_00: return 4'b1110;
            4'b11_01: return 4'b0111;
            4'b11_10: return 4'b0011;
            4'b11_11: return 4'b0001;
            4'b00_00: return 4'b1111;
            4'b00_01: return 4'b0111;
            4'b00_10: return 4'b0011;
            default:  return 4'b0001;
        endcase
    endfunction

    function automatic logic [WORDS*32-1:0] model_image();
        logic [WORDS*32-1:0] img;
        for (int w = 0; w < WORDS; w++) img[w*32 +: 32] = model[w];
        return img;
    endfunction

    // driver: pushes the expected result, then runs one write cycle
    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [1:0] sz,
                             input logic [31:0] d, input int cfg, input bit ds_first);
        item_t it;
        logic [3:0] m;
        int n;
        @(negedge clk);
        addr = a; siz = sz; data = d; rw = 1'b0; wait_cfg = WAIT_W'(cfg);
        m = exp_mask(sz, a[1:0]);
        for (int k = 0; k < 4; k++)
            if (m[k]) model[a[ADDR_W-1:2]][k*8 +: 8] = d[k*8 +: 8];
        it.lat = cfg + 4;
        it.idx = int'(a[ADDR_W-1:2]);
        it.image = model_image();
        sb.push_back(it);
        writes_sent++;
        @(negedge clk); as_n = 1'b0;
        @(negedge clk); ds_n = 1'b0;
        n = 0;
        while (ack_n !== 2'b00 && n < 60) begin @(negedge clk); n++; end
        for (int h = 0; h < 3; h++) begin
            @(negedge clk);
            chk(ack_n === 2'b00, "R5 ack held while strobes low", ack_n, 2'b00);
        end
        if (ds_first) ds_n = 1'b1; else as_n = 1'b1;
        n = 0;
        do begin @(posedge clk); n++; @(negedge clk); end while (ack_n !== 2'b11 && n < 20);
        chk(n == 3, "R6 release edge count", n, 3);
        as_n = 1'b1; ds_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // monitor: measures each write response and compares with the scoreboard
    initial begin
        forever begin
            @(negedge ds_n);
            if (rw === 1'b0) begin
                item_t it;
                int lat;
                it = sb.pop_front();
                lat = 0;
                do begin
                    @(posedge clk); lat++; @(negedge clk);
                    if (ack_n !== 2'b00)
                        chk(ack_n === 2'b11, "R3 ack bits move together", ack_n, 2'b11);
                end while (ack_n !== 2'b00 && lat < 40);
                acks_seen++;
                chk(lat == it.lat, "R4 ack latency", lat, it.lat);
                chk(ack_n === 2'b00, "R3 both ack bits low", ack_n, 2'b00);
                chk(words[it.idx*32 +: 32] === it.image[it.idx*32 +: 32],
                    "R1 lanes stored at ack", words[it.idx*32 +: 32], it.image[it.idx*32 +: 32]);
                chk(words === it.image, "R2 other words unchanged", words, it.image);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int w = 0; w < WORDS; w++) model[w] = '0;
        repeat (3) @(negedge clk);
        chk(ack_n === 2'b11, "R9 ack idle in reset", ack_n, 2'b11);
        chk(words === '0, "R9 storage clear in reset", words, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ack_n === 2'b11, "R9 ack idle after reset", ack_n, 2'b11);

        // long word, aligned, no wait
        bus_write(4'h0, 2'b00, 32'hA1B2C3D4, 0, 1'b0);
        // bytes at every offset of word 1
        bus_write(4'h4, 2'b01, 32'h11000000, 2, 1'b1);
        bus_write(4'h5, 2'b01, 32'h00220000, 5, 1'b0);
        bus_write(4'h6, 2'b01, 32'h00003300, 1, 1'b1);
        bus_write(4'h7, 2'b01, 32'h00000044, 7, 1'b0);
        // word size at every offset of word 2
        bus_write(4'h8, 2'b10, 32'h5566FFFF, 7, 1'b1);
        bus_write(4'h9, 2'b10, 32'hFF7788FF, 3, 1'b0);
        bus_write(4'hA, 2'b10, 32'hFFFF99AA, 0, 1'b1);
        bus_write(4'hB, 2'b10, 32'hEEEEEEBB, 4, 1'b0);
        // three bytes and misaligned long words in word 3
        bus_write(4'hC, 2'b11, 32'h123456FF, 6, 1'b1);
        bus_write(4'hD, 2'b11, 32'hEE9A8B7C, 2, 1'b0);
        bus_write(4'hE, 2'b00, 32'hDDDD6655, 1, 1'b1);
        bus_write(4'hF, 2'b00, 32'hCCCCCC0F, 0, 1'b0);
        bus_write(4'h1, 2'b00, 32'h99FEDCBA, 3, 1'b1);

        // R7: a held read cycle gets no acknowledge and stores nothing
        @(negedge clk);
        addr = 4'h0; siz = 2'b00; data = 32'hDEADBEEF; rw = 1'b1; wait_cfg = '0;
        @(negedge clk); as_n = 1'b0;
        @(negedge clk); ds_n = 1'b0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (c % 4 == 3) chk(ack_n === 2'b11, "R7 no ack on read", ack_n, 2'b11);
        end
        chk(words === model_image(), "R7 read leaves storage", words, model_image());
        as_n = 1'b1; ds_n = 1'b1;
        repeat (4) @(negedge clk);
        rw = 1'b0;

        // R8: back-to-back writes after a read and after each other
        bus_write(4'h2, 2'b01, 32'h00003C00, 0, 1'b0);
        bus_write(4'h3, 2'b01, 32'h0000005A, 7, 1'b1);
        repeat (4) @(negedge clk);
        chk(acks_seen == writes_sent, "R8 every write acknowledged", acks_seen, writes_sent);
        chk(sb.size() == 0, "R8 scoreboard drained", sb.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule